// File: doc/BRIEF.md
# Change-Filtered Trace Sample Collector

The collector takes a wide sample from a set of monitored signals on every rising edge of its clock. It turns those samples into trace elements on a valid/ready output. The sample is divided into equal lanes. Each lane has an enable bit, and a disabled lane reads as zero everywhere inside the block. A one-bit mode picks between two filters. In continuous mode every sample becomes an element. In trace-on-change mode a sample becomes an element only when it differs from the last element that was placed on the output.

A small register file holds four settings: the mode, the lane enables, the trigger lane and a timestamp-on-all flag. Each setting is written by select code and read back by the same code. Each element carries a timestamp-request bit, taken from the flag. It also carries a copy of the lane that the trigger-lane setting picks, for use by a downstream cross-trigger matcher. There is no buffering beyond the output register. A sample that arrives while the output is stalled is dropped, and a sticky overflow flag records that an element was lost.

Top module: `chg_trace_collector`

## Requirements
- R1: After reset, the output is not valid, overflow is clear, the mode reads 0 and the lane-enable register reads all ones.
- R2: In mode 0 (continuous), every sample taken while the output is not stalled appears on the output in the following cycle, with valid high.
- R3: In mode 1 (trace-on-change), a sample whose masked value equals the last element placed on the output produces no element. A sample whose masked value differs produces an element in the following cycle.
- R4: The first sample after reset, and the first sample after any write to the mode register, is emitted in either mode.
- R5: Each lane of 8 bits (lane k is sample bits 8k+7..8k) whose enable bit k is 0 is forced to zero, both in the output data and in the change compare.
- R6: While valid is high and ready is low, the output data is held and incoming samples are dropped. A dropped sample that would have produced an element sets the overflow flag. The flag stays set until the next write to the mode register clears it.
- R7: The timestamp-request bit of each element equals the timestamp-on-all flag in force when its sample was taken.
- R8: The trigger-lane output of each element equals the lane of that element's data that is picked by the trigger-lane register.
- R9: Configuration registers are written with cfg_we_i and read combinationally on cfg_rdata_o. Select 0 is the mode (bit 0), select 1 is the lane enables (bit k = lane k), select 2 is the trigger lane number (bits 2..0) and select 3 is the timestamp-on-all flag (bit 0). Unused read bits are zero. A write takes effect for the sample of the next cycle.
- R10: In trace-on-change mode, the compare reference during and after a stall is the element that was held on the output, not any dropped sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | 64 | Sample taken on every rising edge |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select for write and read |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data of the selected register |
| out_valid_o | output | 1 | Element present |
| out_ready_i | input | 1 | Consumer accepts the element |
| out_data_o | output | 64 | Element data, masked |
| out_ts_req_o | output | 1 | Element requests a timestamp |
| out_trig_lane_o | output | 8 | Selected lane of the element |
| overflow_o | output | 1 | Sticky flag: an element was dropped |

## Verification
The bench targets repeated samples in trace-on-change mode just after reset and just after a mode write. A design that forgets the first-sample rule would stay silent there. It changes only disabled lanes, where a design that compares before masking would emit spurious elements. It stalls the output while different samples arrive and then offers the held value again. A design that compares against the dropped sample would emit a duplicate, and one that does not hold the output or flag the loss shows changed data or a clear overflow.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
    // Configuration register select codes (R9)
    typedef enum logic [1:0] {
        SEL_MODE    = 2'd0,
        SEL_LANE_EN = 2'd1,
        SEL_TRIG    = 2'd2,
        SEL_TS_ALL  = 2'd3
    } cfg_sel_e;

    // Collection mode values
    localparam logic MODE_CONT = 1'b0;
    localparam logic MODE_TOC  = 1'b1;
endpackage

// File: rtl/ctc_cfg_regs.sv
module ctc_cfg_regs
    import ctc_pkg::*;
#(
    parameter int LANES = 8,
    localparam int LSW  = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [1:0]       sel_i,
    input  logic [LANES-1:0] wdata_i,
    output logic [LANES-1:0] rdata_o,
    output logic             mode_o,
    output logic [LANES-1:0] lane_en_o,
    output logic [LSW-1:0]   trig_sel_o,
    output logic             ts_all_o,
    output logic             mode_wr_o
);
    typedef struct packed {
        logic             mode;
        logic [LANES-1:0] lane_en;
        logic [LSW-1:0]   trig_sel;
        logic             ts_all;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Next-value computation (R9)
    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (cfg_sel_e'(sel_i))
                SEL_MODE:    cfg_d.mode     = wdata_i[0];
                SEL_LANE_EN: cfg_d.lane_en  = wdata_i;
                SEL_TRIG:    cfg_d.trig_sel = wdata_i[LSW-1:0];
                SEL_TS_ALL:  cfg_d.ts_all   = wdata_i[0];
                default:     cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode     <= MODE_CONT;
            cfg_q.lane_en  <= '1;
            cfg_q.trig_sel <= '0;
            cfg_q.ts_all   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Combinational readback, unused bits zero
    always_comb begin
        rdata_o = '0;
        case (cfg_sel_e'(sel_i))
            SEL_MODE:    rdata_o[0]       = cfg_q.mode;
            SEL_LANE_EN: rdata_o          = cfg_q.lane_en;
            SEL_TRIG:    rdata_o[LSW-1:0] = cfg_q.trig_sel;
            SEL_TS_ALL:  rdata_o[0]       = cfg_q.ts_all;
            default:     rdata_o = '0;
        endcase
    end

    assign mode_o     = cfg_q.mode;
    assign lane_en_o  = cfg_q.lane_en;
    assign trig_sel_o = cfg_q.trig_sel;
    assign ts_all_o   = cfg_q.ts_all;
    assign mode_wr_o  = we_i && (cfg_sel_e'(sel_i) == SEL_MODE);
endmodule

// File: rtl/ctc_lane_mask.sv
module ctc_lane_mask #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic [DW-1:0]    smp_i,
    input  logic [LANES-1:0] lane_en_i,
    output logic [DW-1:0]    smp_o
);
    // Disabled lanes read as zero (R5)
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign smp_o[k*LANE_W +: LANE_W] =
            lane_en_i[k] ? smp_i[k*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/ctc_emit_ctrl.sv
module ctc_emit_ctrl #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W,
    localparam int LSW   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     smp_i,
    input  logic              mode_i,
    input  logic              ts_all_i,
    input  logic [LSW-1:0]    trig_sel_i,
    input  logic              mode_wr_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DW-1:0]     data_o,
    output logic              ts_o,
    output logic [LANE_W-1:0] trig_o,
    output logic              ovf_o,
    output logic              first_o
);
    typedef struct packed {
        logic              valid;
        logic [DW-1:0]     data;
        logic              ts;
        logic [LANE_W-1:0] trig;
        logic              ovf;
        logic              first;
    } st_t;

    st_t st_d, st_q;
    logic stalled, want;

    always_comb begin
        st_d    = st_q;
        stalled = st_q.valid && !ready_i;
        // data_q always holds the last element placed on the output (R10)
        want    = !mode_i || st_q.first || (smp_i != st_q.data);
        if (stalled) begin
            // R6: output held, sample dropped
            if (want) st_d.ovf = 1'b1;
        end else begin
            st_d.valid = want;
            if (want) begin
                st_d.data  = smp_i;
                st_d.ts    = ts_all_i;
                st_d.trig  = smp_i[int'(trig_sel_i)*LANE_W +: LANE_W];
                st_d.first = 1'b0;
            end
        end
        // R4 / R6: a mode write restarts the filter and clears overflow
        if (mode_wr_i) begin
            st_d.first = 1'b1;
            st_d.ovf   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= 1'b0;
            st_q.data  <= '0;
            st_q.ts    <= 1'b0;
            st_q.trig  <= '0;
            st_q.ovf   <= 1'b0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign data_o  = st_q.data;
    assign ts_o    = st_q.ts;
    assign trig_o  = st_q.trig;
    assign ovf_o   = st_q.ovf;
    assign first_o = st_q.first;
endmodule

// File: rtl/chg_trace_collector.sv
module chg_trace_collector #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W,
    localparam int LSW   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     smp_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [LANES-1:0]  cfg_wdata_i,
    output logic [LANES-1:0]  cfg_rdata_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [DW-1:0]     out_data_o,
    output logic              out_ts_req_o,
    output logic [LANE_W-1:0] out_trig_lane_o,
    output logic              overflow_o
);
    logic             cfg_mode;
    logic [LANES-1:0] cfg_lane_en;
    logic [LSW-1:0]   cfg_trig_sel;
    logic             cfg_ts_all;
    logic             mode_wr;
    logic [DW-1:0]    smp_masked;
    logic             emit_first;

    ctc_cfg_regs #(.LANES(LANES)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we_i),
        .sel_i      (cfg_sel_i),
        .wdata_i    (cfg_wdata_i),
        .rdata_o    (cfg_rdata_o),
        .mode_o     (cfg_mode),
        .lane_en_o  (cfg_lane_en),
        .trig_sel_o (cfg_trig_sel),
        .ts_all_o   (cfg_ts_all),
        .mode_wr_o  (mode_wr)
    );

    ctc_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) u_mask (
        .smp_i     (smp_i),
        .lane_en_i (cfg_lane_en),
        .smp_o     (smp_masked)
    );

    ctc_emit_ctrl #(.LANES(LANES), .LANE_W(LANE_W)) u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_i      (smp_masked),
        .mode_i     (cfg_mode),
        .ts_all_i   (cfg_ts_all),
        .trig_sel_i (cfg_trig_sel),
        .mode_wr_i  (mode_wr),
        .ready_i    (out_ready_i),
        .valid_o    (out_valid_o),
        .data_o     (out_data_o),
        .ts_o       (out_ts_req_o),
        .trig_o     (out_trig_lane_o),
        .ovf_o      (overflow_o),
        .first_o    (emit_first)
    );
endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          overflow,
    input logic          mode_wr,
    input logic          mode,
    input logic          first
);
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !mode_wr |=> overflow);

    // R2
    cont_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode && !(out_valid && !out_ready) |=> out_valid);

    // R4
    first_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first && !(out_valid && !out_ready) |=> out_valid);

    // R3
    no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode && !first && !(out_valid && !out_ready)
        |=> !out_valid || (out_data != $past(out_data)));
endmodule

bind chg_trace_collector ctc_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid_o),
    .out_ready (out_ready_i),
    .out_data  (out_data_o),
    .overflow  (overflow_o),
    .mode_wr   (mode_wr),
    .mode      (cfg_mode),
    .first     (emit_first)
);

// File: tb/tb_chg_trace_collector.sv
`timescale 1ns/1ps
module tb_chg_trace_collector;
    localparam int LANES = 8;
    localparam int LW    = 8;
    localparam int DW    = LANES * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] smp = '0;
    logic          we = 1'b0;
    logic [1:0]    sel = 2'd0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          valid;
    logic          ready = 1'b1;
    logic [DW-1:0] data;
    logic          tsq;
    logic [7:0]    trig;
    logic          ovf;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    logic          m_mode = 1'b0, m_ts = 1'b0;
    logic [7:0]    m_en = 8'hFF;
    logic [2:0]    m_sel = 3'd0;
    logic          m_valid = 1'b0, m_tsq = 1'b0, m_ovf = 1'b0, m_first = 1'b1;
    logic [DW-1:0] m_data = '0;
    logic [7:0]    m_trig = '0;

    always #4 clk = ~clk;

    chg_trace_collector dut (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .cfg_we_i(we), .cfg_sel_i(sel),
        .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .out_valid_o(valid),
        .out_ready_i(ready), .out_data_o(data), .out_ts_req_o(tsq),
        .out_trig_lane_o(trig), .overflow_o(ovf));

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mask_of(input logic [DW-1:0] s, input logic [7:0] en);
        logic [DW-1:0] r = '0;
        for (int k = 0; k < LANES; k++)
            if (en[k]) r[k*LW +: LW] = s[k*LW +: LW];
        return r;
    endfunction

    // advance model by one edge using currently driven inputs
    task automatic model_step();
        logic [DW-1:0] ms = mask_of(smp, m_en);
        logic want = !m_mode || m_first || (ms != m_data);
        if (m_valid && !ready) begin
            if (want) m_ovf = 1'b1;
        end else begin
            m_valid = want;
            if (want) begin
                m_data = ms; m_tsq = m_ts; m_trig = ms[m_sel*LW +: LW]; m_first = 1'b0;
            end
        end
        if (we) begin
            case (sel)
                2'd0: begin m_mode = wdata[0]; m_first = 1'b1; m_ovf = 1'b0; end
                2'd1: m_en = wdata;
                2'd2: m_sel = wdata[2:0];
                default: m_ts = wdata[0];
            endcase
        end
    endtask

    // one cycle: model update, edge, compare at negedge
    task automatic tick();
        string mt = m_mode ? "R3" : "R2";
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(mt, DW'(valid), DW'(m_valid));
        if (m_valid) begin
            chk(m_en == 8'hFF ? mt : "R5", data, m_data);
            chk("R7", DW'(tsq), DW'(m_tsq));
            chk("R8", DW'(trig), DW'(m_trig));
        end
        chk("R6", DW'(ovf), DW'(m_ovf));
        we = 1'b0;
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [7:0] v);
        we = 1'b1; sel = s; wdata = v;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", DW'(valid), '0);
        chk("R1", DW'(ovf), '0);
        sel = 2'd1; #1; chk("R1", DW'(rdata), DW'(8'hFF));
        sel = 2'd0; #1; chk("R1", DW'(rdata), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 continuous: distinct samples every cycle
        for (int i = 0; i < 6; i++) begin
            smp = {$urandom, $urandom};
            tick();
        end

        // R9 readback of every register
        cfg_write(2'd2, 8'h05); sel = 2'd2; #1; chk("R9", DW'(rdata), DW'(8'h05));
        cfg_write(2'd3, 8'h01); sel = 2'd3; #1; chk("R9", DW'(rdata), DW'(8'h01));
        cfg_write(2'd1, 8'hA5); sel = 2'd1; #1; chk("R9", DW'(rdata), DW'(8'hA5));
        cfg_write(2'd1, 8'hFF);

        // R4: switch to trace-on-change, repeated sample still emitted once
        smp = 64'h5555_5555_5555_5555;
        cfg_write(2'd0, 8'h01); sel = 2'd0; #1; chk("R9", DW'(rdata), DW'(1));
        tick(); chk("R4", DW'(valid), DW'(1)); chk("R4", data, 64'h5555_5555_5555_5555);
        tick(); chk("R3", DW'(valid), '0);
        tick(); chk("R3", DW'(valid), '0);

        // R5: lanes 4..7 disabled, change only there -> nothing emitted
        cfg_write(2'd1, 8'h0F);
        tick(); chk("R5", DW'(valid), DW'(1)); chk("R5", data, 64'h0000_0000_5555_5555);
        smp = 64'hDEAD_BEEF_5555_5555;
        tick(); chk("R5", DW'(valid), '0);
        cfg_write(2'd1, 8'hFF);
        tick();

        // R10 / R6: stall, dropped change, then the held value again
        smp = 64'h1111_2222_3333_4444;
        tick(); chk("R3", DW'(valid), DW'(1));
        ready = 1'b0; smp = 64'h9999_8888_7777_6666;
        tick(); chk("R6", data, 64'h1111_2222_3333_4444); chk("R6", DW'(ovf), DW'(1));
        ready = 1'b1; smp = 64'h1111_2222_3333_4444;
        tick(); chk("R10", DW'(valid), '0); chk("R6", DW'(ovf), DW'(1));
        cfg_write(2'd0, 8'h01); chk("R6", DW'(ovf), '0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [DW-1:0] s;
            for (int k = 0; k < LANES; k++) s[k*LW +: LW] = 8'($urandom_range(0, 2));
            if ($urandom_range(0, 3) != 0) s = smp;
            smp = s;
            ready = ($urandom_range(0, 9) < 7);
            if ($urandom_range(0, 24) == 0) begin
                we = 1'b1; sel = 2'($urandom); wdata = 8'($urandom);
                if (sel == 2'd1 && wdata == 8'h00) wdata = 8'h81;
            end
            tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule